// File: doc/BRIEF.md
# Infrared Link Descriptor Ring Sequencer

This block walks a descriptor ring in system memory on behalf of an infrared link controller. The ring is one 1 KiB-aligned region. Receive slots sit in its lower half. Transmit slots start 0x200 bytes above the base. Every slot is eight bytes long. Software sets up the ring through a small byte-wide register port: the packed base address, a size byte that holds one code per direction, and a prompt bit that wakes the engine.

Once prompted, the engine fetches the slot at the current index through a word-wide memory port that uses a request/ready handshake. It processes the slot only if the hardware-ownership bit is set. It then presents the slot's buffer address, length and control byte to the frame datapath and waits for a completion pulse. After that it writes the results back into the slot, which clears ownership. Finally it pulses a done event and advances the index, wrapping at the configured slot count. When the engine reaches a slot that software has not handed over, it stops. It stays stopped until the next prompt. Transmit work is taken before receive work. Only one slot is in flight at a time.

Top module: `ir_ring_seq`

## Requirements
- R1: The ring base is {base_hi[5:0], base_mid[7:0], base_lo[7:0], 10'b0}. The base_lo register is at address 2, base_mid at 3 and base_hi at 4. base_hi reads back with bits 7:6 as zero. Slot n of the receive half is at base + 8n. Slot n of the transmit half is at base + 0x200 + 8n. Every memory request falls inside the 1 KiB ring.
- R2: The size register at address 5 holds the receive code in bits 3:0 and the transmit code in bits 7:4. The codes 0x0, 0x1, 0x3, 0x7 and 0xF give 4, 8, 16, 32 and 64 slots. Each index counts up by one per completed slot and wraps to 0 after count−1.
- R3: The engine works only after a write of 1 to bit 0 of address 6, which reads as 0. It stops at the first slot whose ownership bit is clear. An owned slot that appears after it has stopped is left alone until the next prompt.
- R4: A slot is owned by hardware when bit 7 of its control byte is set. The control byte is byte 3, which is memory word bits 31:24. A slot that is not owned is left unmodified and yields no job.
- R5: For an owned slot, job_valid_o is raised while the engine waits for completion. job_buf_o carries bytes 4–7, job_len_o the low 12 bits of bytes 0–1, job_ctl_o the control byte, and job_tx_o the half the slot belongs to.
- R6: On a receive completion, bytes 0–1 are written first with {4'b0, done_len_i}. Only after that is byte 3 written, with done_flags_i bits 6:1 and bits 7 and 0 cleared. Byte 2 is never written.
- R7: On a transmit completion, only byte 3 is written. Its value keeps the slot's own bits 6:2, clears bits 7 and 1, and sets bit 0 to done_flags_i bit 0 (underrun).
- R8: rx_done_o pulses for one cycle per completed receive slot. tx_done_o pulses for one cycle per completed transmit slot, and only if bit 2 of that slot's control byte was set.
- R9: When both halves have work pending, the transmit half is examined first.
- R10: After reset, both indices, the base and the size read as zero, and no memory request or job is active.
- R11: Once raised, a memory request holds its address, direction and data until mem_ready_i is seen.
- R12: The slot indices read back at address 0 (receive) and address 1 (transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Write data, little-endian |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| job_valid_o | output | 1 | A slot is handed to the frame datapath |
| job_tx_o | output | 1 | Job is from the transmit half |
| job_buf_o | output | 32 | Slot buffer address |
| job_len_o | output | 12 | Slot length field |
| job_ctl_o | output | 8 | Slot control byte as fetched |
| done_valid_i | input | 1 | Frame completion pulse |
| done_len_i | input | 12 | Received length |
| done_flags_i | input | 8 | Completion status flags |
| rx_done_o | output | 1 | Receive slot completed |
| tx_done_o | output | 1 | Transmit slot completed |

## Verification
Every memory access takes two cycles. The bench raises mem_ready_i on the falling edge after it sees a request, and it checks each request's address against the ring base there (R1, R11). A job is compared with the bench's queue of expected slots on the first falling edge where job_valid_o is high. Completion is returned on the third such edge. The result writes land on the following accesses. rx_done_o and tx_done_o are registered, so each is high for the single cycle after the control-byte write completes, and the bench counts them on falling edges. Slot contents and index readbacks are checked only after the ports have been quiet for 20 cycles, so no check depends on the exact sequence length.

// File: rtl/ir_ring_pkg.sv
package ir_ring_pkg;
  localparam int ADDR_W    = 32;
  localparam int NIB_W     = 4;
  localparam int IDX_W     = NIB_W + 2;
  localparam int SLOT_LSB  = 3;
  localparam int ALIGN_LSB = SLOT_LSB + IDX_W + 1;
  localparam int LEN_W     = 12;
  localparam int RA_W      = 3;
  localparam int HI_W      = ADDR_W - ALIGN_LSB - 16;

  localparam logic [RA_W-1:0] RA_RXIDX  = 3'd0;
  localparam logic [RA_W-1:0] RA_TXIDX  = 3'd1;
  localparam logic [RA_W-1:0] RA_BASE_L = 3'd2;
  localparam logic [RA_W-1:0] RA_BASE_M = 3'd3;
  localparam logic [RA_W-1:0] RA_BASE_H = 3'd4;
  localparam logic [RA_W-1:0] RA_SIZE   = 3'd5;
  localparam logic [RA_W-1:0] RA_PROMPT = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_RUN, S_WLEN, S_WCTL} seq_st_e;
endpackage

// File: rtl/ir_ring_regs.sv
module ir_ring_regs
  import ir_ring_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RA_W-1:0]   addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [IDX_W-1:0]  rx_idx_i,
  input  logic [IDX_W-1:0]  tx_idx_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [7:0]        size_o,
  output logic              prompt_o
);
  logic [7:0]      base_l_q, base_m_q, size_q;
  logic [HI_W-1:0] base_h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_l_q <= '0;
      base_m_q <= '0;
      base_h_q <= '0;
      size_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_BASE_L: base_l_q <= wdata_i;
        RA_BASE_M: base_m_q <= wdata_i;
        RA_BASE_H: base_h_q <= wdata_i[HI_W-1:0];
        RA_SIZE:   size_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign base_o   = {base_h_q, base_m_q, base_l_q, {ALIGN_LSB{1'b0}}};
  assign size_o   = size_q;
  assign prompt_o = we_i && (addr_i == RA_PROMPT) && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_RXIDX:  rdata_o = 8'(rx_idx_i);
      RA_TXIDX:  rdata_o = 8'(tx_idx_i);
      RA_BASE_L: rdata_o = base_l_q;
      RA_BASE_M: rdata_o = base_m_q;
      RA_BASE_H: rdata_o = 8'(base_h_q);
      RA_SIZE:   rdata_o = size_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ir_ring_idx.sv
module ir_ring_idx
  import ir_ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] size_nib_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] mask;
  assign mask = {size_nib_i, 2'b11};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (adv_i) idx_o <= (idx_o + 1'b1) & mask;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && idx_o == mask && $stable(size_nib_i) |=> idx_o == '0); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && idx_o < mask |=> idx_o == $past(idx_o) + 1'b1); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_o)); // R2
endmodule

// File: rtl/ir_ring_fsm.sv
module ir_ring_fsm
  import ir_ring_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  rx_idx_i,
  input  logic [IDX_W-1:0]  tx_idx_i,
  input  logic              prompt_i,
  output logic              adv_rx_o,
  output logic              adv_tx_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              job_valid_o,
  output logic              job_tx_o,
  output logic [ADDR_W-1:0] job_buf_o,
  output logic [LEN_W-1:0]  job_len_o,
  output logic [7:0]        job_ctl_o,
  input  logic              done_valid_i,
  input  logic [LEN_W-1:0]  done_len_i,
  input  logic [7:0]        done_flags_i,
  output logic              rx_done_o,
  output logic              tx_done_o
);
  seq_st_e           st_q;
  logic              cur_tx_q;
  logic [1:0]        pend_q, pend_clr;
  logic [LEN_W-1:0]  len_q, dlen_q;
  logic [7:0]        ctl_q, dflg_q, ctl_out;
  logic [ADDR_W-1:0] buf_q, slot_addr;
  logic [IDX_W-1:0]  idx_cur;
  logic              xfer, owned, wb_done;

  assign idx_cur   = cur_tx_q ? tx_idx_i : rx_idx_i;
  assign slot_addr = {base_i[ADDR_W-1:ALIGN_LSB], cur_tx_q, idx_cur, {SLOT_LSB{1'b0}}};
  assign xfer      = mem_req_o && mem_ready_i;
  assign owned     = mem_rdata_i[31];
  assign wb_done   = (st_q == S_WCTL) && xfer;
  // rx: status bits 6:1; tx: keep request bits 6:2, report underrun in bit 0
  assign ctl_out   = cur_tx_q ? {1'b0, ctl_q[6:2], 1'b0, dflg_q[0]}
                              : {1'b0, dflg_q[6:1], 1'b0};

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_be_o    = 4'b0000;
    mem_addr_o  = slot_addr;
    mem_wdata_o = '0;
    case (st_q)
      S_RD0: mem_req_o = 1'b1;
      S_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = slot_addr | ADDR_W'(4);
      end
      S_WLEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 4'b0011;
        mem_wdata_o = {16'b0, {(16-LEN_W){1'b0}}, dlen_q};
      end
      S_WCTL: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 4'b1000;
        mem_wdata_o = {ctl_out, 24'b0};
      end
      default: ;
    endcase
  end

  always_comb begin
    pend_clr = 2'b00;
    if (st_q == S_RD0 && xfer && !owned) pend_clr = cur_tx_q ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cur_tx_q  <= 1'b0;
      pend_q    <= 2'b00;
      len_q     <= '0;
      ctl_q     <= '0;
      buf_q     <= '0;
      dlen_q    <= '0;
      dflg_q    <= '0;
      rx_done_o <= 1'b0;
      tx_done_o <= 1'b0;
    end else begin
      pend_q    <= prompt_i ? 2'b11 : (pend_q & ~pend_clr);
      rx_done_o <= wb_done && !cur_tx_q;
      tx_done_o <= wb_done && cur_tx_q && ctl_q[2];
      case (st_q)
        S_IDLE: begin
          if (pend_q[1]) begin
            cur_tx_q <= 1'b1;
            st_q     <= S_RD0;
          end else if (pend_q[0]) begin
            cur_tx_q <= 1'b0;
            st_q     <= S_RD0;
          end
        end
        S_RD0: if (xfer) begin
          if (owned) begin
            len_q <= mem_rdata_i[LEN_W-1:0];
            ctl_q <= mem_rdata_i[31:24];
            st_q  <= S_RD1;
          end else begin
            st_q  <= S_IDLE;
          end
        end
        S_RD1: if (xfer) begin
          buf_q <= mem_rdata_i;
          st_q  <= S_RUN;
        end
        S_RUN: if (done_valid_i) begin
          dlen_q <= done_len_i;
          dflg_q <= done_flags_i;
          st_q   <= cur_tx_q ? S_WCTL : S_WLEN;
        end
        S_WLEN: if (xfer) st_q <= S_WCTL;
        S_WCTL: if (xfer) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign adv_rx_o    = wb_done && !cur_tx_q;
  assign adv_tx_o    = wb_done && cur_tx_q;
  assign job_valid_o = (st_q == S_RUN);
  assign job_tx_o    = cur_tx_q;
  assign job_buf_o   = buf_q;
  assign job_len_o   = len_q;
  assign job_ctl_o   = ctl_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R11
  AST_LEN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_be_o == 4'b1000 && !cur_tx_q && $past(mem_be_o) != 4'b1000 |-> $past(mem_be_o) == 4'b0011); // R6
  AST_EV_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_done_o && tx_done_o)); // R8
  AST_JOB_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(job_valid_o && mem_req_o)); // R5
  AST_JOB_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o && !done_valid_i |=> job_valid_o && $stable(job_buf_o) && $stable(job_ctl_o)); // R5
endmodule

// File: rtl/ir_ring_seq.sv
module ir_ring_seq
  import ir_ring_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              job_valid_o,
  output logic              job_tx_o,
  output logic [ADDR_W-1:0] job_buf_o,
  output logic [LEN_W-1:0]  job_len_o,
  output logic [7:0]        job_ctl_o,
  input  logic              done_valid_i,
  input  logic [LEN_W-1:0]  done_len_i,
  input  logic [7:0]        done_flags_i,
  output logic              rx_done_o,
  output logic              tx_done_o
);
  logic [ADDR_W-1:0]           base;
  logic [7:0]                  size;
  logic                        prompt;
  logic [1:0]                  adv;
  logic [1:0][IDX_W-1:0]       idx;

  ir_ring_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .rx_idx_i(idx[0]), .tx_idx_i(idx[1]),
    .base_o(base), .size_o(size), .prompt_o(prompt)
  );

  // index 0: receive half, index 1: transmit half
  for (genvar g = 0; g < 2; g++) begin : g_idx
    ir_ring_idx u_idx (
      .clk_i, .rst_ni,
      .size_nib_i(size[g*NIB_W +: NIB_W]),
      .adv_i(adv[g]),
      .idx_o(idx[g])
    );
  end

  ir_ring_fsm u_fsm (
    .clk_i, .rst_ni,
    .base_i(base), .rx_idx_i(idx[0]), .tx_idx_i(idx[1]), .prompt_i(prompt),
    .adv_rx_o(adv[0]), .adv_tx_o(adv[1]),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_ready_i, .mem_rdata_i,
    .job_valid_o, .job_tx_o, .job_buf_o, .job_len_o, .job_ctl_o,
    .done_valid_i, .done_len_i, .done_flags_i,
    .rx_done_o, .tx_done_o
  );

  AST_REQ_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[ADDR_W-1:ALIGN_LSB] == base[ADDR_W-1:ALIGN_LSB]); // R1
endmodule

// File: tb/ir_ring_seq_test.sv
module ir_ring_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        job_valid_o, job_tx_o;
  logic [31:0] job_buf_o;
  logic [11:0] job_len_o;
  logic [7:0]  job_ctl_o;
  logic        done_valid_i = 1'b0;
  logic [11:0] done_len_i = '0;
  logic [7:0]  done_flags_i = '0;
  logic        rx_done_o, tx_done_o;

  always #10 clk = ~clk;

  ir_ring_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_ready_i, .mem_rdata_i,
    .job_valid_o, .job_tx_o, .job_buf_o, .job_len_o, .job_ctl_o,
    .done_valid_i, .done_len_i, .done_flags_i,
    .rx_done_o, .tx_done_o
  );

  typedef struct packed {
    logic        tx;
    logic [31:0] bufa;
    logic [11:0] len;
    logic [7:0]  ctl;
    logic [11:0] dlen;
    logic [7:0]  dflg;
  } job_t;

  int checks = 0, errors = 0;
  int rx_ev = 0, tx_ev = 0;
  int jcnt = 0;
  bit in_job = 0;
  logic [7:0]  mem [0:1023];
  bit          len_wr [0:63];
  logic [31:0] base_exp = '0;
  job_t        expq[$];
  job_t        cur;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory, completion responder and behavioural job model
  always @(negedge clk) begin
    if (rx_done_o) rx_ev++;
    if (tx_done_o) tx_ev++;
    if (mem_ready_i) mem_ready_i = 1'b0;
    else if (mem_req_o) begin
      int a;
      chk("R1 request inside ring", {10'b0, mem_addr_o[31:10]}, {10'b0, base_exp[31:10]});
      a = int'(mem_addr_o[9:0]) & ~3;
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++) if (mem_be_o[b]) mem[a+b] = mem_wdata_o[8*b +: 8];
        if (mem_be_o == 4'b0011 && a < 512) len_wr[a>>3] = 1'b1;
        if (mem_be_o == 4'b1000 && a < 512) begin
          chk("R6 length written before control", 32'(len_wr[a>>3]), 32'd1);
          len_wr[a>>3] = 1'b0;
        end
      end else begin
        mem_rdata_i = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
      end
      mem_ready_i = 1'b1;
    end
    if (done_valid_i) done_valid_i = 1'b0;
    else if (job_valid_o) begin
      if (!in_job) begin
        in_job = 1;
        jcnt = 0;
        if (expq.size() == 0) begin
          chk("R3 unexpected job", 32'd1, 32'd0);
          cur = '0;
        end else begin
          cur = expq.pop_front();
          chk("R9 job half", 32'(job_tx_o), 32'(cur.tx));
          chk("R5 job buffer", job_buf_o, cur.bufa);
          chk("R5 job length", 32'(job_len_o), 32'(cur.len));
          chk("R5 job control", 32'(job_ctl_o), 32'(cur.ctl));
        end
      end
      jcnt++;
      if (jcnt == 3) begin
        done_len_i   = cur.dlen;
        done_flags_i = cur.dflg;
        done_valid_i = 1'b1;
        in_job = 0;
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr_i = a;
    #1 chk(req, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic put_slot(input bit tx, input int i, input logic [15:0] len,
                          input logic [7:0] ctl, input logic [31:0] bufa);
    int o;
    o = (tx ? 512 : 0) + i * 8;
    mem[o] = len[7:0]; mem[o+1] = len[15:8]; mem[o+2] = 8'h5a; mem[o+3] = ctl;
    for (int b = 0; b < 4; b++) mem[o+4+b] = bufa[8*b +: 8];
  endtask

  task automatic expect_job(input bit tx, input int i, input logic [11:0] dlen, input logic [7:0] dflg);
    job_t j;
    int o;
    o = (tx ? 512 : 0) + i * 8;
    j.tx = tx;
    j.bufa = {mem[o+7], mem[o+6], mem[o+5], mem[o+4]};
    j.len = {mem[o+1][3:0], mem[o]};
    j.ctl = mem[o+3];
    j.dlen = dlen;
    j.dflg = dflg;
    expq.push_back(j);
  endtask

  function automatic logic [7:0] ctl_of(input bit tx, input int i);
    return mem[(tx ? 512 : 0) + i * 8 + 3];
  endfunction

  function automatic logic [15:0] len_of(input bit tx, input int i);
    int o;
    o = (tx ? 512 : 0) + i * 8;
    return {mem[o+1], mem[o]};
  endfunction

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 20) begin
      @(negedge clk);
      #1;
      if (!mem_req_o && !job_valid_o && !done_valid_i) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ev0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    for (int i = 0; i < 64; i++) len_wr[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 / R12 reset state
    #1 chk("R10 no request after reset", {30'b0, mem_req_o, job_valid_o}, 32'd0);
    rd_chk("R12 R10 rx index reset", 3'd0, 8'h00);
    rd_chk("R12 R10 tx index reset", 3'd1, 8'h00);
    rd_chk("R10 base reset", 3'd3, 8'h00);
    rd_chk("R10 size reset", 3'd5, 8'h00);

    // R1 base packing
    wr_reg(3'd2, 8'h0d);
    wr_reg(3'd3, 8'hb7);
    wr_reg(3'd4, 8'hff);
    base_exp = {6'h3f, 8'hb7, 8'h0d, 10'h000};
    rd_chk("R1 base low", 3'd2, 8'h0d);
    rd_chk("R1 base mid", 3'd3, 8'hb7);
    rd_chk("R1 base high pads zero", 3'd4, 8'h3f);
    rd_chk("R3 prompt reads zero", 3'd6, 8'h00);
    wr_reg(3'd5, 8'h00);

    // R4 R6 R8 receive slots 0..2, slot 3 not owned
    put_slot(0, 0, 16'hfabc, 8'h80, 32'h0001_1000);
    put_slot(0, 1, 16'h0123, 8'h80, 32'h0001_2000);
    put_slot(0, 2, 16'h0fff, 8'h80, 32'h0001_3000);
    put_slot(0, 3, 16'h0044, 8'h7f, 32'h0001_4000);
    expect_job(0, 0, 12'd100, 8'h02);
    expect_job(0, 1, 12'd101, 8'h62);
    expect_job(0, 2, 12'hfff, 8'hff);
    ev0 = rx_ev;
    wr_reg(3'd6, 8'h01);
    wait_idle();
    chk("R5 all receive jobs taken", 32'(expq.size()), 32'd0);
    rd_chk("R12 rx index after three", 3'd0, 8'h03);
    chk("R6 rx ctl flags eof", 32'(ctl_of(0, 0)), 32'h02);
    chk("R6 rx ctl multiple flags", 32'(ctl_of(0, 1)), 32'h62);
    chk("R6 rx ctl masks bits 7 and 0", 32'(ctl_of(0, 2)), 32'h7e);
    chk("R6 rx length written", 32'(len_of(0, 0)), 32'd100);
    chk("R6 rx length upper nibble zero", 32'(len_of(0, 2)), 32'h0fff);
    chk("R6 byte 2 untouched", 32'(mem[2]), 32'h5a);
    chk("R4 unowned slot untouched", 32'(ctl_of(0, 3)), 32'h7f);
    chk("R4 unowned length untouched", 32'(len_of(0, 3)), 32'h0044);
    chk("R8 rx done per slot", 32'(rx_ev - ev0), 32'd3);

    // R3 owned slot ignored without prompt; R2 wrap at 4
    put_slot(0, 3, 16'h0044, 8'h80, 32'h0001_4000);
    repeat (30) @(negedge clk);
    rd_chk("R3 no work without prompt", 3'd0, 8'h03);
    chk("R3 slot still owned", 32'(ctl_of(0, 3)), 32'h80);
    expect_job(0, 3, 12'd7, 8'h04);
    wr_reg(3'd6, 8'h01);
    wait_idle();
    rd_chk("R2 rx index wraps at four", 3'd0, 8'h00);
    chk("R6 rx ctl bad framing", 32'(ctl_of(0, 3)), 32'h04);

    // R7 R8 transmit, size 8
    wr_reg(3'd5, 8'h10);
    rd_chk("R2 size readback", 3'd5, 8'h10);
    put_slot(1, 0, 16'h0200, 8'hd4, 32'h0002_0000);
    put_slot(1, 1, 16'h0300, 8'h88, 32'h0002_1000);
    expect_job(1, 0, 12'd0, 8'h01);
    expect_job(1, 1, 12'd0, 8'h00);
    ev0 = tx_ev;
    wr_reg(3'd6, 8'h01);
    wait_idle();
    rd_chk("R12 tx index after two", 3'd1, 8'h02);
    chk("R7 tx ctl keeps request bits, underrun", 32'(ctl_of(1, 0)), 32'h55);
    chk("R7 tx ctl no underrun", 32'(ctl_of(1, 1)), 32'h08);
    chk("R7 tx length not written", 32'(len_of(1, 0)), 32'h0200);
    chk("R8 tx done only when requested", 32'(tx_ev - ev0), 32'd1);
    rd_chk("R2 rx index unaffected by tx", 3'd0, 8'h00);

    // R2 transmit wrap at 8
    for (int i = 2; i < 8; i++) begin
      put_slot(1, i, 16'(i), 8'h84, 32'h0003_0000 + 32'(i));
      expect_job(1, i, 12'd0, 8'h00);
    end
    ev0 = tx_ev;
    wr_reg(3'd6, 8'h01);
    wait_idle();
    rd_chk("R2 tx index wraps at eight", 3'd1, 8'h00);
    chk("R8 tx done six", 32'(tx_ev - ev0), 32'd6);
    chk("R7 tx ctl last slot", 32'(ctl_of(1, 7)), 32'h04);

    // R9 transmit before receive
    put_slot(0, 0, 16'h0010, 8'h80, 32'h0004_0000);
    put_slot(1, 0, 16'h0020, 8'h80, 32'h0005_0000);
    expect_job(1, 0, 12'd0, 8'h00);
    expect_job(0, 0, 12'd33, 8'h02);
    wr_reg(3'd6, 8'h01);
    wait_idle();
    chk("R9 both jobs taken", 32'(expq.size()), 32'd0);
    rd_chk("R9 rx index", 3'd0, 8'h01);
    rd_chk("R9 tx index", 3'd1, 8'h01);

    // R2 64-slot receive ring, full lap from index 1
    wr_reg(3'd5, 8'hff);
    for (int i = 0; i < 64; i++) put_slot(0, i, 16'(i), 8'h80, 32'h0006_0000 + 32'(i * 16));
    for (int k = 1; k <= 64; k++) expect_job(0, k % 64, 12'(k), 8'h02);
    ev0 = rx_ev;
    wr_reg(3'd6, 8'h01);
    wait_idle();
    chk("R2 all 64 jobs taken", 32'(expq.size()), 32'd0);
    chk("R8 rx done 64", 32'(rx_ev - ev0), 32'd64);
    rd_chk("R2 rx index after full lap", 3'd0, 8'h01);
    chk("R6 slot 63 released", 32'(ctl_of(0, 63)), 32'h02);
    chk("R6 slot 0 length", 32'(len_of(0, 0)), 32'd64);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule